// File: doc/BRIEF.md
# Reference Phase-Hit Corrector

This block sits between a two-way reference selector and a downstream phase-locked loop. Both timing references arrive as slow pulse streams and are sampled by a fast system clock. The block turns the falling edges of the chosen reference into a one-cycle virtual reference strobe. When the selection moves from one reference to the other, the block works out how far apart the two edge trains are in phase. It then delays every later edge by that amount, so the loop downstream sees the virtual reference keep its phase rather than jump.

A free-running timestamp counter wraps once per reference period. It stamps the latest falling edge of each reference. At each switch, the stamp difference, taken modulo the period, is added to a running offset. Repeated switches therefore keep the original phase. A delay counter loaded with the offset sets when each virtual edge is released.

With the tracking control low, the block is bypassed and edges pass straight through. Holding the control low long enough also clears the offset, which realigns the virtual reference with the selected one. The strobe is a plain pulse with no back-pressure. The loop downstream has to accept it in the cycle it appears.

Top module: `phase_hit_corrector`

## Requirements
- R1: With `track_en` high, a falling edge of the selected reference first sampled low at rising clock edge k produces `vref_stb` high for one cycle after rising edge k+1+`phase_ofs`. There is one strobe per reference period.
- R2: With `track_en` low, a selected falling edge sampled at edge k gives `vref_stb` after edge k+1 with no added delay. Any delayed edge still pending is dropped.
- R3: A change of `use_sec` while `track_en` is high sets `phase_ofs` to (`phase_ofs` + t_old − t_new) mod PERIOD. Here t_old and t_new are the period-wrapped timestamps of the latest falling edges of the old and new references. Virtual strobes keep the same phase within the period across any number of switches.
- R4: `track_en` sampled low on CLR_CYC consecutive rising edges clears `phase_ofs` to 0. The next selected edge then passes with no added delay. A low stretch of CLR_CYC−1 edges leaves `phase_ofs` unchanged.
- R5: `phase_ofs` is always below PERIOD.
- R6: When `phase_ofs` is 0, strobes appear with the same latency as in bypass.
- R7: Changes of `use_sec` made while `track_en` is low do not alter `phase_ofs`.
- R8: While `rst_n` is low, `vref_stb` is 0 and `phase_ofs` is 0.
- R9: `use_sec` = 0 selects `ref_pri`; `use_sec` = 1 selects `ref_sec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pri | input | 1 | First reference pulse stream |
| ref_sec | input | 1 | Second reference pulse stream |
| use_sec | input | 1 | Reference choice: 0 first, 1 second |
| track_en | input | 1 | High: phase correction active; low: bypass, and clear once held long enough |
| vref_stb | output | 1 | One-cycle virtual reference edge strobe |
| phase_ofs | output | PW = clog2(PERIOD) | Offset currently applied to the selected edges, in clock cycles |

## Verification
The main sweep covers every pair of phases the two references can take in a 12-cycle period. For each pair it first confirms that the first reference passes through undelayed. It then switches to the second reference and checks both the stored offset and that every strobe stays on its original phase. A sweep like this separates a correct wrap-around subtraction from one with the wrong sign or a missing modulo, because those faults only show for some phase orderings. Further sequences cover accumulation over two switches with a moved reference, low pulses one cycle short of and at the clear length, a selection change during bypass, and plain bypass on each reference.

// File: rtl/phc_pkg.sv
package phc_pkg;
  localparam int unsigned NREF = 2;

  // (a - b) wrapped into [0, p)
  function automatic int unsigned wrap_sub(input int unsigned a, input int unsigned b,
                                           input int unsigned p);
    return (a >= b) ? (a - b) : (a + p - b);
  endfunction

  // (a + b) wrapped into [0, p) for a, b already below p
  function automatic int unsigned wrap_add(input int unsigned a, input int unsigned b,
                                           input int unsigned p);
    int unsigned s;
    s = a + b;
    return (s >= p) ? (s - p) : s;
  endfunction
endpackage

// File: rtl/phc_edge_stamp.sv
module phc_edge_stamp #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic [PW-1:0] tnow,
  output logic          fall,
  output logic [PW-1:0] stamp
);
  logic cap_q, prev_q;

  assign fall = prev_q & ~cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b1;
      prev_q <= 1'b1;
      stamp  <= '0;
    end else begin
      cap_q  <= ref_in;
      prev_q <= cap_q;
      if (fall) stamp <= tnow;
    end
  end
endmodule

// File: rtl/phc_offset_acc.sv
module phc_offset_acc import phc_pkg::*; #(
  parameter int unsigned PERIOD  = 25000,
  parameter int unsigned CLR_CYC = 20,
  parameter int unsigned PW      = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sel,
  input  logic [PW-1:0] stamp_pri,
  input  logic [PW-1:0] stamp_sec,
  output logic          sel_q,
  output logic [PW-1:0] ofs
);
  localparam int unsigned CW = $clog2(CLR_CYC + 1);
  localparam logic [CW-1:0] LOW_LAST = CW'(CLR_CYC - 1);

  logic [CW-1:0] low_cnt;
  logic          low_hit;
  logic          swap;
  logic [PW-1:0] t_old, t_new, ofs_nxt;

  assign low_hit = !en && (low_cnt == LOW_LAST);
  assign swap    = en && (sel != sel_q);
  assign t_old   = sel_q ? stamp_sec : stamp_pri;
  assign t_new   = sel   ? stamp_sec : stamp_pri;

  always_comb begin
    ofs_nxt = PW'(wrap_add(32'(ofs), wrap_sub(32'(t_old), 32'(t_new), PERIOD), PERIOD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      sel_q   <= 1'b0;
      ofs     <= '0;
    end else begin
      sel_q <= sel;
      if (en)                   low_cnt <= '0;
      else if (!low_hit)        low_cnt <= low_cnt + 1'b1;
      if (low_hit)              ofs <= '0;
      else if (swap)            ofs <= ofs_nxt;
    end
  end
endmodule

// File: rtl/phc_delay_unit.sv
module phc_delay_unit #(
  parameter int unsigned PW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fall,
  input  logic [PW-1:0] ofs,
  output logic          stb,
  output logic          busy
);
  logic [PW-1:0] cnt;
  logic          expire, fire;

  assign expire = busy && (cnt == PW'(1));
  assign fire   = en ? ((fall && ofs == '0) || expire) : fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      stb  <= 1'b0;
    end else begin
      stb <= fire;
      if (!en) begin
        busy <= 1'b0;
      end else if (fall && ofs != '0) begin
        cnt  <= ofs;
        busy <= 1'b1;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        if (expire) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/phase_hit_corrector.sv
module phase_hit_corrector import phc_pkg::*; #(
  parameter  int unsigned PERIOD  = 25000,
  parameter  int unsigned CLR_CYC = 20,
  localparam int unsigned PW      = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_pri,
  input  logic          ref_sec,
  input  logic          use_sec,
  input  logic          track_en,
  output logic          vref_stb,
  output logic [PW-1:0] phase_ofs
);
  logic [PW-1:0]   tnow;
  logic [NREF-1:0] ref_vec, fall_vec;
  logic [PW-1:0]   stamp_vec [NREF];
  logic            sel_q, fall_sel, dly_busy;

  assign ref_vec = {ref_sec, ref_pri};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tnow <= '0;
    else if (tnow == PW'(PERIOD-1)) tnow <= '0;
    else                           tnow <= tnow + 1'b1;
  end

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    phc_edge_stamp #(.PW(PW)) u_stamp (
      .clk   (clk),
      .rst_n (rst_n),
      .ref_in(ref_vec[g]),
      .tnow  (tnow),
      .fall  (fall_vec[g]),
      .stamp (stamp_vec[g])
    );
  end

  phc_offset_acc #(.PERIOD(PERIOD), .CLR_CYC(CLR_CYC), .PW(PW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (track_en),
    .sel      (use_sec),
    .stamp_pri(stamp_vec[0]),
    .stamp_sec(stamp_vec[1]),
    .sel_q    (sel_q),
    .ofs      (phase_ofs)
  );

  assign fall_sel = fall_vec[sel_q];

  phc_delay_unit #(.PW(PW)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (track_en),
    .fall (fall_sel),
    .ofs  (phase_ofs),
    .stb  (vref_stb),
    .busy (dly_busy)
  );
endmodule

// File: rtl/phc_checks.sv
module phc_checks #(
  parameter int unsigned PERIOD = 25000,
  parameter int unsigned PW     = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          track_en,
  input logic          vref_stb,
  input logic [PW-1:0] phase_ofs,
  input logic          fall_sel,
  input logic          dly_busy
);
  AST_OFS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase_ofs) < PERIOD); // R5

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!track_en && fall_sel) |=> vref_stb); // R2

  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !track_en |=> !dly_busy); // R2

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && fall_sel && phase_ofs == '0) |=> vref_stb); // R6

  AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !track_en |=> ($stable(phase_ofs) || phase_ofs == '0)); // R7
endmodule

bind phase_hit_corrector phc_checks #(.PERIOD(PERIOD), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .track_en (track_en),
  .vref_stb (vref_stb),
  .phase_ofs(phase_ofs),
  .fall_sel (fall_sel),
  .dly_busy (dly_busy)
);

// File: tb/tb_phase_hit_corrector.sv
module tb_phase_hit_corrector;
  localparam int P    = 12;
  localparam int CLR  = 20;
  localparam int PW   = $clog2(P);
  localparam int WDOG = 120000;

  logic clk = 1'b0;
  logic rst_n, ref_pri, ref_sec, use_sec, track_en;
  logic vref_stb;
  logic [PW-1:0] phase_ofs;

  int n = 0, vecs = 0, errs = 0, stb_cnt = 0;
  int pa = 0, pb = 0, exp_ph = 0;
  bit chk_on = 0, done = 0;
  string ph_req = "R1";

  always #2.5 clk = ~clk;

  phase_hit_corrector #(.PERIOD(P), .CLR_CYC(CLR)) dut (
    .clk(clk), .rst_n(rst_n), .ref_pri(ref_pri), .ref_sec(ref_sec),
    .use_sec(use_sec), .track_en(track_en), .vref_stb(vref_stb), .phase_ofs(phase_ofs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, n);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  // references: each falls for one cycle once per period at its own phase
  always @(negedge clk) begin
    n = n + 1;
    if (rst_n && vref_stb) begin
      stb_cnt++;
      if (chk_on) chk((n % P) == exp_ph, {ph_req, " strobe phase"}, n % P, exp_ph);
    end
    ref_pri = ((n % P) != pa);
    ref_sec = ((n % P) != pb);
    if (n > WDOG && !done) begin
      chk(0, "watchdog", n, WDOG);
      finish_run();
    end
  end

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  task automatic window(input string req);
    stb_cnt = 0;
    wait_cyc(4 * P);
    chk(stb_cnt == 4, {req, " strobes per 4 periods"}, stb_cnt, 4);
  endtask

  task automatic check_ofs(input string req, input int exp);
    chk(int'(phase_ofs) == exp, {req, " phase_ofs"}, int'(phase_ofs), exp);
    chk(int'(phase_ofs) < P, "R5 offset bound", int'(phase_ofs), P - 1);
  endtask

  task automatic run_case(input int a, input int b);
    chk_on = 0; track_en = 0; use_sec = 0; pa = a; pb = b;
    wait_cyc(P + CLR + 2);
    check_ofs("R4 clear", 0);
    exp_ph = (a + 2) % P; ph_req = "R1 R6 R9"; chk_on = 1; track_en = 1;
    window("R1");
    use_sec = 1; ph_req = "R3";
    wait_cyc(2 * P);
    check_ofs("R3 switch", (a - b + P) % P);
    window("R3");
  endtask

  initial begin
    rst_n = 0; track_en = 0; use_sec = 0; ref_pri = 1; ref_sec = 1;
    wait_cyc(5);
    chk(vref_stb == 1'b0, "R8 reset strobe", int'(vref_stb), 0);
    chk(phase_ofs == '0, "R8 reset offset", int'(phase_ofs), 0);
    rst_n = 1;

    for (int a = 0; a < P; a++)
      for (int b = 0; b < P; b++)
        run_case(a, b);

    // accumulation over two switches with the idle reference moved (R3)
    run_case(0, 5);
    ph_req = "R3 accumulate";
    pa = 3;
    wait_cyc(2 * P);
    use_sec = 0;
    wait_cyc(2 * P);
    check_ofs("R3 accumulate", 9);
    window("R3 accumulate");

    // low stretch one short of the clear length keeps the offset (R4)
    chk_on = 0; track_en = 0;
    wait_cyc(CLR - 1);
    track_en = 1;
    check_ofs("R4 short low", 9);
    wait_cyc(2 * P);
    ph_req = "R1 after short low"; chk_on = 1;
    window("R1");

    // selection changed during bypass does not move the offset (R7)
    chk_on = 0; track_en = 0;
    wait_cyc(2);
    use_sec = 1;
    wait_cyc(2);
    track_en = 1;
    check_ofs("R7 bypass reselect", 9);
    exp_ph = (5 + 2 + 9) % P;
    wait_cyc(2 * P);
    ph_req = "R7"; chk_on = 1;
    window("R7");

    // plain bypass on the second reference, then on the first (R2, R9)
    chk_on = 0; track_en = 0;
    wait_cyc(P);
    exp_ph = (pb + 2) % P; ph_req = "R2"; chk_on = 1;
    window("R2");
    check_ofs("R4 long low", 0);
    chk_on = 0; use_sec = 0;
    wait_cyc(P);
    exp_ph = (pa + 2) % P; ph_req = "R9 bypass"; chk_on = 1;
    window("R9");

    // exactly the clear length realigns; first edge undelayed (R4)
    chk_on = 0; track_en = 1; use_sec = 1;
    wait_cyc(2 * P);
    check_ofs("R4 setup", (3 - 5 + P) % P);
    track_en = 0;
    wait_cyc(CLR);
    track_en = 1;
    check_ofs("R4 exact clear", 0);
    wait_cyc(P);
    exp_ph = (pb + 2) % P; ph_req = "R4 realign"; chk_on = 1;
    window("R4");

    chk_on = 0;
    finish_run();
  end
endmodule